// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller with Boot-Block Lockout

This block models the control side of a word-wide parallel NOR flash. A host writes command sequences over a simple bus of address, data, write strobe and read strobe. The controller decodes them and runs word programming, region erase, chip erase, product identification and a permanent boot-block write lock against a small internal word array. Each program or erase holds a busy timer for a fixed number of clock cycles. While the timer runs, the controller ignores new writes, and reads return polling status instead of array data.

The array keeps 2^SLOT_W words for the boot region (word addresses below BOOT_WORDS, 0000h-1FFFh by default) and the same number for the main region. A word is selected by its region and its low SLOT_W address bits, so addresses in the same region alias modulo 2^SLOT_W. A region erase clears the whole region that contains the given address. A digital override input stands in for the high-voltage bypass of the lock.

Top module: `nflash_ctrl`

## Requirements
- R1: Reset state and reads. After a synchronous reset (rst_n low), busy is 0, rdata is 0000h and identification mode is off. When not busy, a read strobe returns the addressed array word on rdata after the next rising edge.
- R2: While busy is 1, every write is ignored. No new operation starts, and the command decoder state does not change.
- R3: Word program is four writes: AAh@5555h, 55h@2AAAh, A0h@5555h, then data@target. The stored word becomes the old word AND the new data, so programming only clears bits.
- R4: busy rises at the clock edge that takes the final command write. It stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase. The array result is readable once busy falls.
- R5: The lock sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 40h@5555h. It sets the lock at once without going busy. The lock is never cleared, including by rst_n.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h enters identification mode. The same sequence with F0h exits it. In identification mode, a read of address 0 returns MFR_ID, address 1 returns DEV_ID, and address 2 returns the lock state on bit 0 (1 = locked) with the other bits 0.
- R7: While locked and lock_override is low, a program or region erase aimed at the boot region is dropped with no busy period. A chip erase then clears only the main region. With lock_override held high for the whole operation, boot writes proceed. If the override drops before the operation completes, the boot region is left unchanged.
- R8: While a program is busy, any read returns bit 7 equal to the complement of bit 7 of the data being programmed, with all other bits 0. While an erase is busy, any read returns 0000h.
- R9: A reset during a program ends the operation and writes 0000h to the target word.
- R10: A write that does not match the expected cycle of a sequence returns the decoder to idle, so later cycles of that sequence do nothing.
- R11: Region erase is the first five lock-sequence writes followed by 30h at any address in the region. It sets every word of that region to FFFFh. Chip erase uses 10h@5555h as the sixth write and sets every word to FFFFh, subject to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| rd_en | input | 1 | Bus read strobe; rdata updates at the next edge |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; bits 7:0 carry command codes |
| lock_override | input | 1 | Bypasses the boot lock while held high |
| rdata | output | 16 | Registered read data or status |
| busy | output | 1 | High while a program or erase is timed |

## Verification
The checker examines every cycle: no operation may launch from a write taken while busy, and busy may only rise after a launch. It also checks the polling status word during program and erase, that the lock never clears, and that no boot-region array update happens while locked without the override. The bench scenarios cover the rest: AND-merging on reprogram, exact busy lengths, aborted sequences, region and chip erase, the identification codes, override release in mid-operation, and word corruption when reset arrives during a program.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_CHIP = 2'd2} op_e;

  localparam logic [15:0] SEQ_ADDR_A = 16'h5555;
  localparam logic [15:0] SEQ_ADDR_B = 16'h2AAA;

  localparam logic [7:0] CODE_KEY_A  = 8'hAA;
  localparam logic [7:0] CODE_KEY_B  = 8'h55;
  localparam logic [7:0] CODE_PROG   = 8'hA0;
  localparam logic [7:0] CODE_ERPRE  = 8'h80;
  localparam logic [7:0] CODE_IDON   = 8'h90;
  localparam logic [7:0] CODE_IDOFF  = 8'hF0;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_REGION = 8'h30;
  localparam logic [7:0] CODE_LOCK   = 8'h40;

  // programming can only clear bits
  function automatic logic [15:0] merge_prog(input logic [15:0] old_w, input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  // status word returned while a program is running
  function automatic logic [15:0] poll_word(input logic data_b7);
    return {8'h00, ~data_b7, 7'h00};
  endfunction
endpackage

// File: rtl/nfc_busy_timer.sv
module nfc_busy_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= len;
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/nfc_cmd_decode.sv
module nfc_cmd_decode
  import nfc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        code,
  output logic              c_prog,
  output logic              c_region,
  output logic              c_chip,
  output logic              c_lock,
  output logic              c_id_on,
  output logic              c_id_off
);
  typedef enum logic [2:0] {S_IDLE, S_K1, S_K2, S_E3, S_E4, S_E5, S_PD} st_e;
  st_e st_q, st_d;

  logic at_a, at_b;
  assign at_a = (addr == ADDR_W'(SEQ_ADDR_A));
  assign at_b = (addr == ADDR_W'(SEQ_ADDR_B));

  always_comb begin
    st_d     = st_q;
    c_prog   = 1'b0;
    c_region = 1'b0;
    c_chip   = 1'b0;
    c_lock   = 1'b0;
    c_id_on  = 1'b0;
    c_id_off = 1'b0;
    if (wr) begin
      st_d = S_IDLE;
      unique case (st_q)
        S_IDLE: if (at_a && code == CODE_KEY_A) st_d = S_K1;
        S_K1:   if (at_b && code == CODE_KEY_B) st_d = S_K2;
        S_K2: if (at_a) begin
          if (code == CODE_PROG)  st_d = S_PD;
          if (code == CODE_ERPRE) st_d = S_E3;
          c_id_on  = (code == CODE_IDON);
          c_id_off = (code == CODE_IDOFF);
        end
        S_E3: if (at_a && code == CODE_KEY_A) st_d = S_E4;
        S_E4: if (at_b && code == CODE_KEY_B) st_d = S_E5;
        S_E5: begin
          c_region = (code == CODE_REGION);
          c_chip   = at_a && (code == CODE_CHIP);
          c_lock   = at_a && (code == CODE_LOCK);
        end
        S_PD: c_prog = 1'b1;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/nflash_ctrl.sv
module nflash_ctrl
  import nfc_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          BOOT_WORDS   = 8192,
  parameter int          SLOT_W       = 4,
  parameter int          PROG_CYCLES  = 200,
  parameter int          ERASE_CYCLES = 2000,
  parameter logic [15:0] MFR_ID       = 16'h00C5,
  parameter logic [15:0] DEV_ID       = 16'h5A21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              lock_override,
  output logic [15:0]       rdata,
  output logic              busy
);
  localparam int IDX_W  = SLOT_W + 1;
  localparam int NWORDS = 1 << IDX_W;
  localparam int MAXCYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W  = $clog2(MAXCYC + 1);

  function automatic logic in_boot(input logic [ADDR_W-1:0] a);
    return a < ADDR_W'(BOOT_WORDS);
  endfunction

  // index MSB 0 = boot region, 1 = main region
  function automatic logic [IDX_W-1:0] arr_idx(input logic [ADDR_W-1:0] a);
    return {~in_boot(a), a[SLOT_W-1:0]};
  endfunction

  logic [15:0] mem [NWORDS];

  logic c_prog, c_region, c_chip, c_lock, c_id_on, c_id_off;
  logic wr_live, boot_hit, blocked, launch, done;
  logic [CNT_W-1:0] run_len;
  op_e  op_q, op_d;
  logic [IDX_W-1:0] tgt_idx_q;
  logic [15:0] tgt_data_q;
  logic guard_q, lost_q, id_q, boot_ok, tgt_boot;
  logic lock_q = 1'b0;
  logic [15:0] rdata_q;

  // named events for the checker
  logic boot_wr_ev, prog_busy, poll_bit7;

  assign wr_live = wr_en & ~busy;

  nfc_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr(wr_live), .addr(addr), .code(wdata[7:0]),
    .c_prog(c_prog), .c_region(c_region), .c_chip(c_chip), .c_lock(c_lock),
    .c_id_on(c_id_on), .c_id_off(c_id_off)
  );

  assign boot_hit = in_boot(addr);
  assign blocked  = lock_q & ~lock_override & boot_hit;
  assign launch   = ((c_prog | c_region) & ~blocked) | c_chip;
  assign op_d     = c_prog ? OP_PROG : (c_region ? OP_SECT : OP_CHIP);
  assign run_len  = c_prog ? CNT_W'(PROG_CYCLES) : CNT_W'(ERASE_CYCLES);

  nfc_busy_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(launch), .len(run_len), .busy(busy), .last(done)
  );

  always_ff @(posedge clk) begin
    if (launch) begin
      op_q       <= op_d;
      tgt_idx_q  <= arr_idx(addr);
      tgt_data_q <= wdata;
      guard_q    <= lock_q & (c_chip | boot_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      lost_q <= 1'b0;
    else if (launch)                 lost_q <= 1'b0;
    else if (busy && !lock_override) lost_q <= 1'b1;
  end

  assign boot_ok    = ~(guard_q & (lost_q | ~lock_override));
  assign tgt_boot   = ~tgt_idx_q[IDX_W-1];
  assign boot_wr_ev = done & boot_ok & ((op_q == OP_CHIP) | tgt_boot);
  assign prog_busy  = busy & (op_q == OP_PROG);
  assign poll_bit7  = tgt_data_q[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (prog_busy) mem[tgt_idx_q] <= '0;
    end else if (done) begin
      unique case (op_q)
        OP_PROG: if (boot_ok || !tgt_boot)
          mem[tgt_idx_q] <= merge_prog(mem[tgt_idx_q], tgt_data_q);
        OP_SECT: for (int i = 0; i < NWORDS; i++) begin
          if (((i >> SLOT_W) != 0) == tgt_idx_q[IDX_W-1] && (boot_ok || !tgt_boot))
            mem[i] <= '1;
        end
        default: for (int i = 0; i < NWORDS; i++) begin
          if ((i >> SLOT_W) != 0 || boot_ok) mem[i] <= '1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (c_lock) lock_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        id_q <= 1'b0;
    else if (c_id_on)  id_q <= 1'b1;
    else if (c_id_off) id_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) begin
      if (busy)      rdata_q <= prog_busy ? poll_word(poll_bit7) : 16'h0000;
      else if (id_q) begin
        if (addr == ADDR_W'(0))      rdata_q <= MFR_ID;
        else if (addr == ADDR_W'(1)) rdata_q <= DEV_ID;
        else if (addr == ADDR_W'(2)) rdata_q <= {15'h0, lock_q};
        else                         rdata_q <= 16'h0000;
      end else       rdata_q <= mem[arr_idx(addr)];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/nflash_ctrl_chk.sv
module nflash_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        busy,
  input logic [15:0] rdata,
  input logic        launch,
  input logic        prog_busy,
  input logic        poll_bit7,
  input logic        lock_q,
  input logic        lock_override,
  input logic        boot_wr_ev
);
  AST_NO_LAUNCH_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |-> !launch); // R2
  AST_BUSY_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch)); // R4
  AST_POLL_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy && rd_en |=> (rdata[7] == !$past(poll_bit7)) && (rdata[6:0] == 7'h0) && (rdata[15:8] == 8'h0)); // R8
  AST_POLL_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !prog_busy && rd_en |=> rdata == 16'h0000); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q); // R5
  AST_LOCKED_BOOT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_wr_ev |-> (!lock_q || lock_override)); // R7
endmodule

bind nflash_ctrl nflash_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .busy(busy), .rdata(rdata),
  .launch(launch), .prog_busy(prog_busy), .poll_bit7(poll_bit7), .lock_q(lock_q),
  .lock_override(lock_override), .boot_wr_ev(boot_wr_ev)
);

// File: tb/nflash_ctrl_bench.sv
module nflash_ctrl_bench;
  localparam int PROG_N  = 20;
  localparam int ERASE_N = 30;
  localparam logic [15:0] MFR = 16'h00C5;
  localparam logic [15:0] DEV = 16'h5A21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, lock_override = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic busy;
  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  nflash_ctrl #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N), .MFR_ID(MFR), .DEV_ID(DEV)) u_nflash_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .lock_override(lock_override), .rdata(rdata), .busy(busy)
  );

  // {write, requirement number, address, data}; reads compare data
  localparam int NV = 45;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1,4'd11,16'h5555,16'h00AA}, {1'b1,4'd11,16'h2AAA,16'h0055}, {1'b1,4'd11,16'h5555,16'h0080},
    {1'b1,4'd11,16'h5555,16'h00AA}, {1'b1,4'd11,16'h2AAA,16'h0055}, {1'b1,4'd11,16'h5555,16'h0010},
    {1'b0,4'd11,16'h0010,16'hFFFF},                                     // R11 chip erase
    {1'b1,4'd3,16'h5555,16'h00AA}, {1'b1,4'd3,16'h2AAA,16'h0055}, {1'b1,4'd3,16'h5555,16'h00A0},
    {1'b1,4'd3,16'h0010,16'h1234}, {1'b0,4'd3,16'h0010,16'h1234},         // R3 program
    {1'b1,4'd3,16'h5555,16'h00AA}, {1'b1,4'd3,16'h2AAA,16'h0055}, {1'b1,4'd3,16'h5555,16'h00A0},
    {1'b1,4'd3,16'h0010,16'hFF0F}, {1'b0,4'd3,16'h0010,16'h1204},         // R3 AND merge
    {1'b1,4'd3,16'h5555,16'h00AA}, {1'b1,4'd3,16'h2AAA,16'h0055}, {1'b1,4'd3,16'h5555,16'h00A0},
    {1'b1,4'd3,16'h4003,16'hABCD}, {1'b0,4'd3,16'h4003,16'hABCD},         // R3 main region
    {1'b1,4'd10,16'h5555,16'h00AA}, {1'b1,4'd10,16'h1111,16'h0055}, {1'b1,4'd10,16'h5555,16'h00A0},
    {1'b1,4'd10,16'h4004,16'h0000}, {1'b0,4'd10,16'h4004,16'hFFFF},       // R10 broken sequence
    {1'b1,4'd11,16'h5555,16'h00AA}, {1'b1,4'd11,16'h2AAA,16'h0055}, {1'b1,4'd11,16'h5555,16'h0080},
    {1'b1,4'd11,16'h5555,16'h00AA}, {1'b1,4'd11,16'h2AAA,16'h0055}, {1'b1,4'd11,16'h4000,16'h0030},
    {1'b0,4'd11,16'h4003,16'hFFFF}, {1'b0,4'd11,16'h0010,16'h1204},       // R11 region erase
    {1'b1,4'd6,16'h5555,16'h00AA}, {1'b1,4'd6,16'h2AAA,16'h0055}, {1'b1,4'd6,16'h5555,16'h0090},
    {1'b0,4'd6,16'h0000,MFR}, {1'b0,4'd6,16'h0001,DEV}, {1'b0,4'd6,16'h0002,16'h0000}, // R6 id codes
    {1'b1,4'd6,16'h5555,16'h00AA}, {1'b1,4'd6,16'h2AAA,16'h0055}, {1'b1,4'd6,16'h5555,16'h00F0},
    {1'b0,4'd6,16'h0010,16'h1204}                                       // R6 exit
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic cmd3(input logic [7:0] c);
    bus_write(16'h5555, 16'h00AA); bus_write(16'h2AAA, 16'h0055); bus_write(16'h5555, {8'h00, c});
  endtask

  task automatic erase6(input logic [15:0] a, input logic [7:0] c);
    cmd3(8'h80); bus_write(16'h5555, 16'h00AA); bus_write(16'h2AAA, 16'h0055); bus_write(a, {8'h00, c});
  endtask

  task automatic prog4(input logic [15:0] a, input logic [15:0] d);
    cmd3(8'hA0); bus_write(a, d);
  endtask

  initial begin
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset busy", {15'h0, busy}, 16'h0000);
    check("R1 reset rdata", rdata, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][36]) begin
        bus_write(VEC[i][31:16], VEC[i][15:0]);
        wait_idle(n);
      end else begin
        bus_read(VEC[i][31:16], v);
        check($sformatf("R%0d table step %0d", VEC[i][35:32], i), v, VEC[i][15:0]);
      end
    end

    // R4 program busy length
    prog4(16'h0012, 16'h0055);
    wait_idle(n);
    check("R4 program busy cycles", 16'(n), 16'(PROG_N));
    bus_read(16'h0012, v); check("R3 program after busy", v, 16'h0055);

    // R8 polling, R2 writes ignored while busy
    prog4(16'h0011, 16'h0070);
    bus_read(16'h0011, v); check("R8 program poll", v, 16'h0080);
    prog4(16'h4005, 16'h0000);
    check("R2 still busy", {15'h0, busy}, 16'h0001);
    wait_idle(n);
    bus_read(16'h0011, v); check("R4 result after busy", v, 16'h0070);
    bus_read(16'h4005, v); check("R2 ignored program", v, 16'hFFFF);

    erase6(16'h4000, 8'h30);
    bus_read(16'h4003, v); check("R8 erase poll", v, 16'h0000);
    wait_idle(n);
    check("R4 erase busy cycles", 16'(n), 16'(ERASE_N - 2));

    // R5 lock, R6 lock readback
    erase6(16'h5555, 8'h40);
    check("R5 lock not busy", {15'h0, busy}, 16'h0000);
    cmd3(8'h90);
    bus_read(16'h0002, v); check("R6 lock readback", v, 16'h0001);
    cmd3(8'hF0);
    bus_read(16'h0010, v); check("R6 normal after exit", v, 16'h1204);

    // R7 locked boot
    prog4(16'h0013, 16'h0000);
    check("R7 boot program dropped busy", {15'h0, busy}, 16'h0000);
    bus_read(16'h0013, v); check("R7 boot word kept", v, 16'hFFFF);
    prog4(16'h4006, 16'h1111); wait_idle(n);
    bus_read(16'h4006, v); check("R7 main program", v, 16'h1111);
    erase6(16'h0000, 8'h30);
    check("R7 boot erase dropped busy", {15'h0, busy}, 16'h0000);
    bus_read(16'h0010, v); check("R7 boot after region erase", v, 16'h1204);
    erase6(16'h5555, 8'h10); wait_idle(n);
    bus_read(16'h0010, v); check("R7 boot after chip erase", v, 16'h1204);
    bus_read(16'h4006, v); check("R11 main after chip erase", v, 16'hFFFF);

    lock_override = 1'b1;
    prog4(16'h0013, 16'h00AA); wait_idle(n);
    bus_read(16'h0013, v); check("R7 override program", v, 16'h00AA);
    prog4(16'h0014, 16'h0000);
    @(negedge clk); lock_override = 1'b0;
    wait_idle(n);
    bus_read(16'h0014, v); check("R7 override dropped", v, 16'hFFFF);

    // R9 reset during program
    prog4(16'h4007, 16'h1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    check("R1 busy after reset", {15'h0, busy}, 16'h0000);
    bus_read(16'h4007, v); check("R9 corrupted word", v, 16'h0000);
    cmd3(8'h90);
    bus_read(16'h0002, v); check("R5 lock survives reset", v, 16'h0001);
    cmd3(8'hF0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule